// File: doc/BRIEF.md
# Nibble-Serial Add/Subtract Unit with Flag Byte

This block performs 8-bit addition and subtraction with one 4-bit adder that it uses twice. After a start pulse it sends the low nibbles of the operands through the adder. It then sends the high nibbles through the same adder, with the carry from the first pass as the carry in. The carry between the two nibbles is not thrown away. It is kept as a half-carry bit in a flag byte that software can see. A later decimal-correction step can read it there, and an interrupt handler can save and restore it.

The flag byte holds carry, half-carry, subtract, parity/overflow, zero and sign bits. The whole byte can be loaded from outside in one write, so a saved context comes back exactly as it was. A separate displacement-add operation produces a sum and leaves the stored carry bit as it was. Address arithmetic can therefore run between two steps of a multi-byte calculation without disturbing it.

Top module: `nibble_alu`

## Requirements
- R1: The unit accepts `start_i` on a rising edge only when `busy_o` is low. `busy_o` is high from the next cycle on. `result_o` and `flags_o` take their new values at the third rising edge after the accepting edge. `done_o` is high for exactly that one cycle, and `busy_o` is low after the edge that follows.
- R2: Op code 000 (ADD) gives A+B mod 256. Op code 001 (ADC) gives A+B+C mod 256, where C is flag bit 0 before the operation. For both, C becomes the carry out of bit 7.
- R3: Op code 010 (SUB) gives A-B mod 256. Op code 011 (SBC) gives A-B-C mod 256. For both, C (bit 0) becomes 1 exactly when the subtraction borrows out of bit 7.
- R4: H (flag bit 4) becomes the carry from bit 3 into bit 4 for additions. For SUB and SBC it becomes the borrow from bit 4 into bit 3.
- R5: N (flag bit 1) becomes 1 after SUB and SBC, and 0 after ADD, ADC and the displacement add.
- R6: Z (bit 6) is 1 when the 8-bit result is zero. S (bit 7) equals result bit 7. P/V (bit 2) is 1 on two's-complement overflow.
- R7: Op code 100 (displacement add) gives A+B mod 256 with carry in 0. It updates S, Z, H, P/V and N, and leaves C (bit 0) at its previous value.
- R8: `flag_we_i` high while `busy_o` is low loads `flag_wdata_i` into the flag byte at the next edge. Bits 5 and 3 always read 0. `flag_we_i` while `busy_o` is high has no effect.
- R9: A start pulse while `busy_o` is high is ignored. The operation in progress finishes with its own operands, and no second `done_o` pulse follows.
- R10: Op codes 101, 110 and 111 behave exactly like ADD.
- R11: After reset, `flags_o`, `result_o`, `busy_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| op_i | input | 3 | Operation code |
| opa_i | input | 8 | First operand A |
| opb_i | input | 8 | Second operand B |
| flag_we_i | input | 1 | Load the flag byte from `flag_wdata_i` |
| flag_wdata_i | input | 8 | Flag byte value to restore |
| result_o | output | 8 | Result of the last completed operation |
| flags_o | output | 8 | Current flag byte |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when result and flags are updated |

## Verification
The properties assume the inputs are driven cleanly and synchronously. They also assume that `start_i` and `flag_we_i` are not raised in the same idle cycle, because the carry-in would then depend on which of the two writes wins. The bench changes inputs only on falling edges. It performs each flag restore in a cycle of its own before the start pulse. It raises start or flag writes during busy only when it is testing that they are ignored.

// File: rtl/nsa_pkg.sv
package nsa_pkg;

    localparam int FLAG_W = 8;

    // flag byte bit positions
    localparam int FB_C  = 0;
    localparam int FB_N  = 1;
    localparam int FB_PV = 2;
    localparam int FB_H  = 4;
    localparam int FB_Z  = 6;
    localparam int FB_S  = 7;

    localparam logic [FLAG_W-1:0] FLAG_MASK = 8'hD7;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBC  = 3'd3,
        OP_DISP = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DONE = 2'd3
    } state_e;

endpackage

// File: rtl/nsa_nibble_adder.sv
module nsa_nibble_adder #(
    parameter int NW = 4
) (
    input  logic [NW-1:0] a_i,
    input  logic [NW-1:0] b_i,
    input  logic          cin_i,
    output logic [NW-1:0] sum_o,
    output logic          cout_o
);
    logic [NW:0] full;

    always_comb begin
        full   = {1'b0, a_i} + {1'b0, b_i} + {{NW{1'b0}}, cin_i};
        sum_o  = full[NW-1:0];
        cout_o = full[NW];
    end
endmodule

// File: rtl/nsa_flag_unit.sv
module nsa_flag_unit
    import nsa_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0]     res_i,
    input  logic              c_mid_i,   // adder carry out of the low pass
    input  logic              c_top_i,   // adder carry out of the high pass
    input  logic              is_sub_i,
    input  logic              keep_c_i,
    input  logic              old_c_i,
    input  logic              a_msb_i,
    input  logic              b_msb_i,   // msb of the operand the adder saw
    output logic [FLAG_W-1:0] flags_o
);
    always_comb begin
        flags_o        = '0;
        flags_o[FB_S]  = res_i[DW-1];
        flags_o[FB_Z]  = (res_i == '0);
        flags_o[FB_H]  = is_sub_i ? ~c_mid_i : c_mid_i;
        flags_o[FB_PV] = (a_msb_i == b_msb_i) && (res_i[DW-1] != a_msb_i);
        flags_o[FB_N]  = is_sub_i;
        flags_o[FB_C]  = keep_c_i ? old_c_i : (is_sub_i ? ~c_top_i : c_top_i);
    end
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
    import nsa_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [DW-1:0]     opa_i,
    input  logic [DW-1:0]     opb_i,
    input  logic              flag_we_i,
    input  logic [FLAG_W-1:0] flag_wdata_i,
    output logic [DW-1:0]     result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int NW = DW / 2;

    typedef struct packed {
        state_e            state;
        logic [DW-1:0]     opa;
        logic [DW-1:0]     opb;     // already inverted for subtraction
        logic              cin;
        logic              is_sub;
        logic              keep_c;
        logic [NW-1:0]     lo_sum;
        logic              hc;      // raw adder carry out of the low pass
        logic [DW-1:0]     result;
        logic [FLAG_W-1:0] flags;
    } st_t;

    st_t st_q, st_d;

    logic [NW-1:0]     add_a, add_b, add_sum;
    logic              add_cin, add_cout;
    logic [FLAG_W-1:0] new_flags;

    // single nibble adder shared by both passes
    always_comb begin
        if (st_q.state == ST_HI) begin
            add_a   = st_q.opa[DW-1:NW];
            add_b   = st_q.opb[DW-1:NW];
            add_cin = st_q.hc;
        end else begin
            add_a   = st_q.opa[NW-1:0];
            add_b   = st_q.opb[NW-1:0];
            add_cin = st_q.cin;
        end
    end

    nsa_nibble_adder #(.NW(NW)) u_adder (
        .a_i    (add_a),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    nsa_flag_unit #(.DW(DW)) u_flags (
        .res_i    ({add_sum, st_q.lo_sum}),
        .c_mid_i  (st_q.hc),
        .c_top_i  (add_cout),
        .is_sub_i (st_q.is_sub),
        .keep_c_i (st_q.keep_c),
        .old_c_i  (st_q.flags[FB_C]),
        .a_msb_i  (st_q.opa[DW-1]),
        .b_msb_i  (st_q.opb[DW-1]),
        .flags_o  (new_flags)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                if (flag_we_i) begin
                    st_d.flags = flag_wdata_i & FLAG_MASK;
                end
                if (start_i) begin
                    st_d.state  = ST_LO;
                    st_d.opa    = opa_i;
                    st_d.is_sub = (op_i == OP_SUB) || (op_i == OP_SBC);
                    st_d.keep_c = (op_i == OP_DISP);
                    st_d.opb    = st_d.is_sub ? ~opb_i : opb_i;
                    case (op_i)
                        OP_ADC:  st_d.cin = st_q.flags[FB_C];
                        OP_SUB:  st_d.cin = 1'b1;
                        OP_SBC:  st_d.cin = ~st_q.flags[FB_C];
                        default: st_d.cin = 1'b0;
                    endcase
                end
            end
            ST_LO: begin
                st_d.lo_sum = add_sum;
                st_d.hc     = add_cout;
                st_d.state  = ST_HI;
            end
            ST_HI: begin
                st_d.result = {add_sum, st_q.lo_sum};
                st_d.flags  = new_flags;
                st_d.state  = ST_DONE;
            end
            ST_DONE: begin
                st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign flags_o  = st_q.flags;
    assign busy_o   = (st_q.state != ST_IDLE);
    assign done_o   = (st_q.state == ST_DONE);

    // R1: done follows an accepted start after three edges
    a_r1_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |-> ##3 done_o);

    // R1 and R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: displacement add keeps the carry bit
    a_r7_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_HI && st_q.keep_c) |=> flags_o[FB_C] == $past(flags_o[FB_C]));

    // R5: subtract bit reflects the operation type at completion
    a_r5_sub_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flags_o[FB_N] == st_q.is_sub);

    // R6: zero bit agrees with the result
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flags_o[FB_Z] == (result_o == '0));

    // R8: idle flag load is visible on the next cycle
    a_r8_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && !busy_o) |=> flags_o == ($past(flag_wdata_i) & FLAG_MASK));

    // R8: unused bits never set
    a_r8_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_o[5] && !flags_o[3]);

endmodule

// File: tb/nibble_alu_bench.sv
`timescale 1ns/1ps
module nibble_alu_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] opa_i = 8'h00;
    logic [7:0] opb_i = 8'h00;
    logic       flag_we_i = 1'b0;
    logic [7:0] flag_wdata_i = 8'h00;
    logic [7:0] result_o, flags_o;
    logic       busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nibble_alu u_nibble_alu (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_i         (op_i),
        .opa_i        (opa_i),
        .opb_i        (opb_i),
        .flag_we_i    (flag_we_i),
        .flag_wdata_i (flag_wdata_i),
        .result_o     (result_o),
        .flags_o      (flags_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    // {op, a, b, flags before, expected result, expected flags}
    localparam logic [42:0] VEC [0:11] = '{
        {3'd0, 8'h39, 8'h48, 8'h00, 8'h81, 8'h94}, // R2 R4 R6 half carry, overflow
        {3'd0, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h51}, // R2 R6 zero with carry
        {3'd1, 8'h10, 8'h0F, 8'h01, 8'h20, 8'h10}, // R2 ADC uses carry
        {3'd2, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h12}, // R3 R4 half borrow
        {3'd2, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h93}, // R3 full borrow
        {3'd3, 8'h50, 8'h20, 8'h01, 8'h2F, 8'h12}, // R3 SBC uses carry
        {3'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h16}, // R6 subtract overflow
        {3'd4, 8'hF0, 8'h20, 8'h01, 8'h10, 8'h01}, // R7 carry kept at 1
        {3'd4, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h50}, // R7 carry kept at 0
        {3'd2, 8'h42, 8'h42, 8'h00, 8'h00, 8'h42}, // R5 R6 zero after subtract
        {3'd5, 8'h01, 8'h02, 8'h01, 8'h03, 8'h00}, // R10 spare code is ADD
        {3'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h94}  // R6 sign and overflow
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4:       return "R7";
            default:    return "R10";
        endcase
    endfunction

    task automatic load_flags(input logic [7:0] v);
        @(negedge clk);
        flag_we_i    = 1'b1;
        flag_wdata_i = v;
        @(negedge clk);
        flag_we_i    = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] fin, input logic [7:0] er, input logic [7:0] ef);
        load_flags(fin);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 busy after start", {7'd0, busy_o}, 8'd1);
        @(negedge clk);
        chk("R1 no early done", {7'd0, done_o}, 8'd0);
        @(negedge clk);
        chk("R1 done on third edge", {7'd0, done_o}, 8'd1);
        chk(op_req(op), result_o, er);
        chk("R4 R5 R6 flags", flags_o, ef);
        @(negedge clk);
        chk("R1 idle after done", {6'd0, busy_o, done_o}, 8'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 flags", flags_o, 8'h00);
        chk("R11 result", result_o, 8'h00);
        chk("R11 busy/done", {6'd0, busy_o, done_o}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            run_op(VEC[i][42:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16],
                   VEC[i][15:8], VEC[i][7:0]);
        end

        // R8 restore full byte, bits 5 and 3 read zero
        load_flags(8'hFF);
        chk("R8 load all ones", flags_o, 8'hD7);
        load_flags(8'h12);
        chk("R8 restore H and N", flags_o, 8'h12);

        // R9 start while busy is ignored
        load_flags(8'h00);
        start_i = 1'b1; op_i = 3'd0; opa_i = 8'h11; opb_i = 8'h22;
        @(negedge clk);
        op_i = 3'd2; opa_i = 8'hF0; opb_i = 8'hF0;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R9 first operation result", result_o, 8'h33);
        chk("R9 first operation flags", flags_o, 8'h00);
        @(negedge clk);
        @(negedge clk);
        chk("R9 no second done", {6'd0, busy_o, done_o}, 8'd0);
        chk("R9 result unchanged", result_o, 8'h33);

        // R8 flag write during busy has no effect; R7 keeps C = 0
        load_flags(8'h00);
        start_i = 1'b1; op_i = 3'd4; opa_i = 8'h01; opb_i = 8'h01;
        @(negedge clk);
        start_i = 1'b0;
        flag_we_i = 1'b1; flag_wdata_i = 8'hFF;
        @(negedge clk);
        flag_we_i = 1'b0;
        chk("R8 busy write ignored", flags_o, 8'h00);
        @(negedge clk);
        chk("R7 result", result_o, 8'h02);
        chk("R8 flags after busy write", flags_o, 8'h00);
        @(negedge clk);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule